// File: doc/BRIEF.md
# Quad-Channel Interrupt Output Steering

This block sits at the pin edge of a four-channel serial controller. It decides how each channel's interrupt request reaches the board. It also presents the transmit-ready and receive-ready status of every channel as active-low pins, plus a combined pin for each direction.

A strap input chooses one of two host bus styles.

- **Per-channel style.** Each channel owns an interrupt pin. The pin is active high when driven. Its output enable comes from that channel's modem-control bit 3. An interrupt-select input can override those bits and enable every pin at once.
- **Shared style.** The channel 0 pin becomes a single device interrupt that is active low and open drain. It pulls low while any channel has a pending request and is released otherwise. The remaining pins drive a constant 0.

Each interrupt pin is presented as a data signal plus an output-enable signal, rather than as a tri-state net. A build parameter can tie the interrupt-select input high permanently, which gives the always-enabled variant. All outputs are registered once, so every output reflects the inputs sampled at the previous rising clock edge.

Top module: `irq_steer_top`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the next output state has all of the following: `irq_pin_oe` = 0, `irq_pin_d` = 0, `txrdy_n` and `rxrdy_n` all ones, and `txrdy_any_n` = `rxrdy_any_n` = 1.
- R2: With `bus_mode_sel` = 1 (per-channel style), `irq_pin_d[i]` equals `irq_pend[i]` sampled one edge earlier.
- R3: In per-channel style, with `irq_sel` = 0 and `INTSEL_TIED` = 0, `irq_pin_oe[i]` equals `mcr_out2[i]` sampled one edge earlier.
- R4: In per-channel style, with `irq_sel` = 1, every `irq_pin_oe` bit is 1 regardless of `mcr_out2`.
- R5: With `bus_mode_sel` = 0 (shared style), `irq_pin_d[0]` is always 0. `irq_pin_oe[0]` is 1 exactly when any `irq_pend` bit was 1 one edge earlier, which is the open-drain pull-low.
- R6: In shared style, pins 1 to 3 have `irq_pin_d` = 0 and `irq_pin_oe` = 1, so they drive a constant 0.
- R7: In shared style, neither `irq_sel` nor `mcr_out2` has any effect on the interrupt pin outputs.
- R8: `txrdy_n[i]` is the inverse of `tx_ready[i]`, and `rxrdy_n[i]` is the inverse of `rx_ready[i]`, each with one edge of latency.
- R9: `txrdy_any_n` is 0 exactly when at least one `tx_ready` bit was 1. `rxrdy_any_n` behaves the same way for `rx_ready`.
- R10: With `INTSEL_TIED` = 1, per-channel style enables every interrupt pin even when `irq_sel` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_mode_sel | input | 1 | Bus style strap: 1 selects per-channel pins, 0 selects the shared open-drain pin |
| irq_sel | input | 1 | Override that enables all interrupt pins in per-channel style |
| mcr_out2 | input | NUM_CH | Modem-control bit 3 for each channel |
| irq_pend | input | NUM_CH | Pending-interrupt flag for each channel |
| tx_ready | input | NUM_CH | Transmit-ready flag for each channel, active high |
| rx_ready | input | NUM_CH | Receive-ready flag for each channel, active high |
| irq_pin_d | output | NUM_CH | Data value for each interrupt pin |
| irq_pin_oe | output | NUM_CH | Output enable for each interrupt pin |
| txrdy_n | output | NUM_CH | Transmit-ready pin for each channel, active low |
| rxrdy_n | output | NUM_CH | Receive-ready pin for each channel, active low |
| txrdy_any_n | output | 1 | Combined transmit-ready pin, active low |
| rxrdy_any_n | output | 1 | Combined receive-ready pin, active low |

## Verification
The hardest case to reach is shared style with the select input held high against the rule. In that case the override and the modem-control bits must both be shown to have no effect on the open-drain pin and on the constant-0 pins. The stimulus produces it with a directed phase that holds shared style while it sweeps `irq_sel` and all `mcr_out2` patterns under changing pending flags. A second instance is built with the select tied high. That instance is driven with the same inputs, so the bonded variant is compared cycle by cycle against the strapped one.

// File: rtl/irq_steer_pkg.sv
// Shared types for the interrupt steering block.
// Assumes: a bus style is a single strap bit.
package irq_steer_pkg;
    typedef enum logic {
        BUS_SHARED = 1'b0,
        BUS_PERCH  = 1'b1
    } bus_style_e;

    // One pin as a data value plus its output enable.
    typedef struct packed {
        logic d;
        logic oe;
    } pin_drive_t;
endpackage

// File: rtl/irq_sel_resolve.sv
// Works out the effective interrupt-select level.
// Assumes: INTSEL_TIED=1 models a select input that is bonded high inside the package.
module irq_sel_resolve #(
    parameter bit INTSEL_TIED = 1'b0
) (
    input  logic sel_in,
    output logic sel_eff
);
    generate
        if (INTSEL_TIED) begin : g_tied
            // The override is always active; the select input is unused.
            logic unused_sel;
            assign unused_sel = sel_in;
            assign sel_eff    = 1'b1;
        end else begin : g_pin
            // Pass the select input through unchanged.
            assign sel_eff = sel_in;
        end
    endgenerate
endmodule

// File: rtl/irq_pin_drive.sv
// Next-state drive for one channel's interrupt pin.
// Channel 0 doubles as the shared open-drain device interrupt.
// Higher channels are parked at a driven 0 in shared style.
// Assumes: any_pend is the OR of all channels' pending flags.
module irq_pin_drive
    import irq_steer_pkg::*;
#(
    parameter int CH_IDX = 0
) (
    input  bus_style_e style,
    input  logic       sel_eff,
    input  logic       mcr_bit,
    input  logic       pend,
    input  logic       any_pend,
    output pin_drive_t drive
);
    generate
        if (CH_IDX == 0) begin : g_shared_owner
            // Per-channel pin, or the open-drain pull-low in shared style.
            always_comb begin
                if (style == BUS_PERCH) begin
                    drive.d  = pend;
                    drive.oe = sel_eff | mcr_bit;
                end else begin
                    drive.d  = 1'b0;
                    drive.oe = any_pend;
                end
            end
        end else begin : g_plain
            // Per-channel pin, or a constant driven 0 in shared style.
            logic unused_any;
            assign unused_any = any_pend;
            always_comb begin
                if (style == BUS_PERCH) begin
                    drive.d  = pend;
                    drive.oe = sel_eff | mcr_bit;
                end else begin
                    drive.d  = 1'b0;
                    drive.oe = 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/rdy_combine.sv
// Turns per-channel ready flags into active-low pins and one combined pin.
// The combined pin is low while any channel is ready, matching a wired
// connection of the individual active-low pins.
module rdy_combine #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] ready,
    output logic [NUM_CH-1:0] ready_n,
    output logic              any_n
);
    // Invert each flag and merge the flags into the combined pin.
    always_comb begin
        ready_n = ~ready;
        any_n   = ~(|ready);
    end
endmodule

// File: rtl/irq_steer_top.sv
// Interrupt and ready pin steering for a multi-channel serial controller.
// All outputs are registered once; reset parks every interrupt pin undriven
// and every ready pin inactive.
// Assumes: the strap is static in normal use, but it may change at any edge.
module irq_steer_top
    import irq_steer_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter bit INTSEL_TIED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_mode_sel,
    input  logic              irq_sel,
    input  logic [NUM_CH-1:0] mcr_out2,
    input  logic [NUM_CH-1:0] irq_pend,
    input  logic [NUM_CH-1:0] tx_ready,
    input  logic [NUM_CH-1:0] rx_ready,
    output logic [NUM_CH-1:0] irq_pin_d,
    output logic [NUM_CH-1:0] irq_pin_oe,
    output logic [NUM_CH-1:0] txrdy_n,
    output logic [NUM_CH-1:0] rxrdy_n,
    output logic              txrdy_any_n,
    output logic              rxrdy_any_n
);
    localparam logic [NUM_CH-1:0] ALL_ONES = {NUM_CH{1'b1}};

    bus_style_e        style;
    logic              sel_eff;
    logic              any_pend;
    pin_drive_t        drv_nxt [NUM_CH];
    logic [NUM_CH-1:0] d_nxt, oe_nxt;
    logic [NUM_CH-1:0] txn_nxt, rxn_nxt;
    logic              txa_nxt, rxa_nxt;

    assign style    = bus_style_e'(bus_mode_sel);
    assign any_pend = |irq_pend;

    irq_sel_resolve #(.INTSEL_TIED(INTSEL_TIED)) u_sel (
        .sel_in  (irq_sel),
        .sel_eff (sel_eff)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
            irq_pin_drive #(.CH_IDX(gi)) u_pin (
                .style    (style),
                .sel_eff  (sel_eff),
                .mcr_bit  (mcr_out2[gi]),
                .pend     (irq_pend[gi]),
                .any_pend (any_pend),
                .drive    (drv_nxt[gi])
            );
            assign d_nxt[gi]  = drv_nxt[gi].d;
            assign oe_nxt[gi] = drv_nxt[gi].oe;
        end
    endgenerate

    rdy_combine #(.NUM_CH(NUM_CH)) u_tx (
        .ready   (tx_ready),
        .ready_n (txn_nxt),
        .any_n   (txa_nxt)
    );

    rdy_combine #(.NUM_CH(NUM_CH)) u_rx (
        .ready   (rx_ready),
        .ready_n (rxn_nxt),
        .any_n   (rxa_nxt)
    );

    // Output register stage with synchronous reset to the safe pin state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pin_d   <= '0;
            irq_pin_oe  <= '0;
            txrdy_n     <= ALL_ONES;
            rxrdy_n     <= ALL_ONES;
            txrdy_any_n <= 1'b1;
            rxrdy_any_n <= 1'b1;
        end else begin
            irq_pin_d   <= d_nxt;
            irq_pin_oe  <= oe_nxt;
            txrdy_n     <= txn_nxt;
            rxrdy_n     <= rxn_nxt;
            txrdy_any_n <= txa_nxt;
            rxrdy_any_n <= rxa_nxt;
        end
    end
endmodule

// File: rtl/irq_steer_chk.sv
// Protocol checker for irq_steer_top, attached by bind.
// Assumes: outputs follow the inputs from the previous edge.
module irq_steer_chk #(
    parameter int NUM_CH      = 4,
    parameter bit INTSEL_TIED = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_mode_sel,
    input logic              irq_sel,
    input logic [NUM_CH-1:0] mcr_out2,
    input logic [NUM_CH-1:0] irq_pend,
    input logic [NUM_CH-1:0] tx_ready,
    input logic [NUM_CH-1:0] rx_ready,
    input logic [NUM_CH-1:0] irq_pin_d,
    input logic [NUM_CH-1:0] irq_pin_oe,
    input logic [NUM_CH-1:0] txrdy_n,
    input logic [NUM_CH-1:0] rxrdy_n,
    input logic              txrdy_any_n,
    input logic              rxrdy_any_n
);
    localparam logic [NUM_CH-1:0] ALL_ONES = {NUM_CH{1'b1}};
    localparam logic              TIED     = INTSEL_TIED;

    // R1: the first edge after reset still shows the reset pin state.
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (irq_pin_oe == '0 && txrdy_n == ALL_ONES && rxrdy_any_n));

    // R2: the per-channel data follows the pending flags.
    a_r2_perch_data: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_mode_sel)) |-> irq_pin_d == $past(irq_pend));

    // R3: the modem-control bits alone gate the enables.
    a_r3_mcr_gates: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_mode_sel) && !$past(irq_sel) && !TIED)
        |-> irq_pin_oe == $past(mcr_out2));

    // R4 and R10: the override enables every pin.
    a_r4_override_all: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_mode_sel) && ($past(irq_sel) || TIED))
        |-> irq_pin_oe == ALL_ONES);

    // R5: the shared pin only ever pulls low, and only while a request is pending.
    a_r5_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_mode_sel))
        |-> (!irq_pin_d[0] && irq_pin_oe[0] == ($countones($past(irq_pend)) != 0)));

    // R6: the other pins drive a constant 0 in shared style.
    a_r6_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_mode_sel))
        |-> (irq_pin_d == '0 && irq_pin_oe[NUM_CH-1:1] == ALL_ONES[NUM_CH-1:1]));

    // R8: the per-channel ready pins are inverted flags.
    a_r8_ready_inv: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (txrdy_n == ~$past(tx_ready) && rxrdy_n == ~$past(rx_ready)));

    // R9: each combined pin agrees with its per-channel pins.
    a_r9_combined: assert property (@(posedge clk) disable iff (!rst_n)
        (txrdy_any_n == ($countones(~txrdy_n) == 0)) &&
        (rxrdy_any_n == ($countones(~rxrdy_n) == 0)));
endmodule

bind irq_steer_top irq_steer_chk #(.NUM_CH(NUM_CH), .INTSEL_TIED(INTSEL_TIED)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_mode_sel (bus_mode_sel),
    .irq_sel      (irq_sel),
    .mcr_out2     (mcr_out2),
    .irq_pend     (irq_pend),
    .tx_ready     (tx_ready),
    .rx_ready     (rx_ready),
    .irq_pin_d    (irq_pin_d),
    .irq_pin_oe   (irq_pin_oe),
    .txrdy_n      (txrdy_n),
    .rxrdy_n      (rxrdy_n),
    .txrdy_any_n  (txrdy_any_n),
    .rxrdy_any_n  (rxrdy_any_n)
);

// File: tb/sim_irq_steer_top.sv
// Bench for irq_steer_top: a behavioural reference model is compared on every clock.
module sim_irq_steer_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_mode_sel = 1'b1;
    logic         irq_sel = 1'b0;
    logic [N-1:0] mcr_out2 = '0;
    logic [N-1:0] irq_pend = '0;
    logic [N-1:0] tx_ready = '0;
    logic [N-1:0] rx_ready = '0;

    logic [N-1:0] d0, oe0, txn0, rxn0, d1, oe1, txn1, rxn1;
    logic         txa0, rxa0, txa1, rxa1;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    irq_steer_top #(.NUM_CH(N), .INTSEL_TIED(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_mode_sel(bus_mode_sel), .irq_sel(irq_sel),
        .mcr_out2(mcr_out2), .irq_pend(irq_pend), .tx_ready(tx_ready), .rx_ready(rx_ready),
        .irq_pin_d(d0), .irq_pin_oe(oe0), .txrdy_n(txn0), .rxrdy_n(rxn0),
        .txrdy_any_n(txa0), .rxrdy_any_n(rxa0));

    irq_steer_top #(.NUM_CH(N), .INTSEL_TIED(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_mode_sel(bus_mode_sel), .irq_sel(irq_sel),
        .mcr_out2(mcr_out2), .irq_pend(irq_pend), .tx_ready(tx_ready), .rx_ready(rx_ready),
        .irq_pin_d(d1), .irq_pin_oe(oe1), .txrdy_n(txn1), .rxrdy_n(rxn1),
        .txrdy_any_n(txa1), .rxrdy_any_n(rxa1));

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model values captured at the rising edge.
    int  e_d, e_oe0, e_oe1, e_txn, e_rxn, e_txa, e_rxa;
    bit  e_rst, e_perch, e_sel, e_r7;

    // Apply one set of inputs, model the edge, and compare after it.
    task automatic step(input bit rn, input bit mode, input bit sel,
                        input int mcr, input int pend, input int tx, input int rx);
        rst_n        = rn;
        bus_mode_sel = mode;
        irq_sel      = sel;
        mcr_out2     = mcr[N-1:0];
        irq_pend     = pend[N-1:0];
        tx_ready     = tx[N-1:0];
        rx_ready     = rx[N-1:0];
        @(posedge clk);
        e_rst   = !rn;
        e_perch = mode;
        e_sel   = sel;
        e_r7    = !mode && (sel || mcr != 0);
        if (!rn) begin
            e_d = 0; e_oe0 = 0; e_oe1 = 0;
            e_txn = 15; e_rxn = 15; e_txa = 1; e_rxa = 1;
        end else begin
            e_txn = (~tx) & 15;
            e_rxn = (~rx) & 15;
            e_txa = ((tx & 15) == 0) ? 1 : 0;
            e_rxa = ((rx & 15) == 0) ? 1 : 0;
            if (mode) begin
                e_d   = pend & 15;
                e_oe0 = sel ? 15 : (mcr & 15);
                e_oe1 = 15;
            end else begin
                e_d   = 0;
                e_oe0 = 14 | (((pend & 15) != 0) ? 1 : 0);
                e_oe1 = e_oe0;
            end
        end
        @(negedge clk);
        if (e_rst) begin
            chk("R1", "reset d", int'(d0), 0);
            chk("R1", "reset oe", int'(oe0), 0);
            chk("R1", "reset txrdy_n", int'(txn0), 15);
            chk("R1", "reset rxrdy_n", int'(rxn0), 15);
            chk("R1", "reset any", int'({txa0, rxa0}), 3);
            chk("R1", "reset oe tied", int'(oe1), 0);
        end else begin
            if (e_perch) begin
                chk("R2", "pin data", int'(d0), e_d);
                chk(e_sel ? "R4" : "R3", "pin enables", int'(oe0), e_oe0);
                chk("R10", "tied enables", int'(oe1), e_oe1);
            end else begin
                chk(e_r7 ? "R7" : "R5", "shared pin data", int'(d0[0]), 0);
                chk(e_r7 ? "R7" : "R5", "shared pin pull", int'(oe0[0]), e_oe0 & 1);
                chk(e_r7 ? "R7" : "R6", "parked data", int'(d0[N-1:1]), 0);
                chk(e_r7 ? "R7" : "R6", "parked enables", int'(oe0[N-1:1]), e_oe0 >> 1);
                chk("R7", "tied shared oe", int'(oe1), e_oe1);
            end
            chk("R8", "txrdy_n", int'(txn0), e_txn);
            chk("R8", "rxrdy_n", int'(rxn0), e_rxn);
            chk("R9", "txrdy_any_n", int'(txa0), e_txa);
            chk("R9", "rxrdy_any_n", int'(rxa0), e_rxa);
        end
    endtask

    // Main stimulus: directed phases, then mixed random traffic.
    initial begin
        @(negedge clk);
        repeat (3) step(1'b0, 1'b1, 1'b1, 15, 15, 15, 15);
        // Per-channel style, bit-3 gating only (R3).
        for (int m = 0; m < 16; m++) step(1'b1, 1'b1, 1'b0, m, 15 - m, m, 0);
        // Per-channel style with the override (R4).
        for (int m = 0; m < 16; m++) step(1'b1, 1'b1, 1'b1, m, m, 0, m);
        // Shared style, legal select, single and multiple pending (R5, R6).
        for (int p = 0; p < 16; p++) step(1'b1, 1'b0, 1'b0, 0, p, p, 15 - p);
        // Shared style with the select and bit 3 forced (R7).
        for (int m = 0; m < 16; m++) begin
            step(1'b1, 1'b0, 1'b1, m, 0, 1, 1);
            step(1'b1, 1'b0, m[0], m, 1 << (m % 4), 8, 0);
        end
        // Reset in the middle of activity (R1).
        step(1'b0, 1'b0, 1'b0, 15, 15, 15, 15);
        step(1'b1, 1'b1, 1'b0, 5, 10, 0, 0);
        // Random traffic including strap changes.
        for (int k = 0; k < 600; k++) begin
            int r;
            r = int'($urandom);
            step((r & 255) != 0, r[8], r[9], (r >> 10) & 15, (r >> 14) & 15,
                 (r >> 18) & 15, (r >> 22) & 15);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule